// File: doc/BRIEF.md
# Memory Barrier Issue Gate

This block sits in front of a load/store issue stage and decides, for each of four kinds of memory barrier, when newer loads and newer stores may issue and when the barrier is finished. It reads the number of older loads and older stores still in flight. From those counts and the barrier kind it drives two separate stall lines, one for new loads and one for new stores. It also drives a one-cycle flush request to the prefetch buffer and a one-cycle completion pulse.

A barrier is offered through a request line with a 2-bit kind code and is taken only while the ready output is high. The block holds at most one barrier. It becomes pending in the cycle after it is accepted and stays pending until its wait condition is seen true. Some kinds stall both access classes. Others let newer loads continue while older traffic drains.

Top module: `barrier_gate`

## Requirements
- R1: After reset, `barReady` is 1 and `loadStall`, `storeStall`, `flushReq` and `barDone` are all 0.
- R2: A request is accepted at a clock edge where `barReq` and `barReady` are both 1. `barReady` is 0 from the next cycle through the cycle in which `barDone` pulses. A request raised while `barReady` is 0 has no effect.
- R3: Kind code 00 (full sync) raises both stalls in every pending cycle. It completes in the first pending cycle in which both `pendLoads` and `pendStores` are 0.
- R4: Kind code 01 (light sync) raises `storeStall` but not `loadStall` in every pending cycle. It completes in the first pending cycle in which both counts are 0.
- R5: Kind code 10 (I/O store order) raises `storeStall` but not `loadStall`. It completes in the first pending cycle in which `pendStores` is 0, whatever the value of `pendLoads`.
- R6: Kind code 11 (instruction sync) pulses `flushReq` for exactly the first pending cycle. It raises both stalls in that cycle and in the next one, and completes in that second cycle.
- R7: `barDone` is a single-cycle pulse. In the cycle after it, both stalls are 0 and `barReady` is 1.
- R8: If the wait condition already holds in the first pending cycle, `barDone` pulses in that cycle, one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pendLoads | input | CNT_W | Number of older loads still in flight |
| pendStores | input | CNT_W | Number of older stores still in flight |
| barReq | input | 1 | Barrier request |
| barType | input | 2 | Barrier kind: 00 full, 01 light, 10 I/O store order, 11 instruction sync |
| barReady | output | 1 | High when a new barrier can be taken |
| loadStall | output | 1 | Hold back newer loads |
| storeStall | output | 1 | Hold back newer stores |
| flushReq | output | 1 | One-cycle prefetch discard request |
| barDone | output | 1 | One-cycle pulse when the pending barrier completes |

## Verification
Two events can fall in the same cycle: the retirement pulse and the start of pending, when the counts are already zero as the barrier is taken. A second pair is the retirement pulse and a fresh request, which must be refused in that cycle and taken in the next. The sweep varies, for every kind, the cycle in which loads and in which stores drain, including zero delay. It holds a conflicting instruction-sync request high through the pending window and checks that no flush appears. A directed case keeps a request high across the completion cycle and checks that it is accepted exactly one cycle later.

// File: rtl/barrier_pkg.sv
package barrier_pkg;

  typedef enum logic [1:0] {
    BAR_FULL  = 2'b00,
    BAR_LIGHT = 2'b01,
    BAR_IO    = 2'b10,
    BAR_ISYNC = 2'b11
  } barKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic holdLoads;
    logic holdStores;
    logic needLoadsIdle;
    logic needStoresIdle;
  } gateStrobes_t;

endpackage

// File: rtl/barrier_datapath.sv
module barrier_datapath
  import barrier_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] pendLoads,
  input  logic [CNT_W-1:0] pendStores,
  input  gateStrobes_t     strb,
  output logic             condMet,
  output logic             loadStall,
  output logic             storeStall
);

  localparam logic [CNT_W-1:0] ZERO_CNT = '0;

  logic loadsIdle;
  logic storesIdle;

  assign loadsIdle  = (pendLoads == ZERO_CNT);
  assign storesIdle = (pendStores == ZERO_CNT);

  assign condMet = (!strb.needLoadsIdle || loadsIdle) &&
                   (!strb.needStoresIdle || storesIdle);

  assign loadStall  = strb.holdLoads;
  assign storeStall = strb.holdStores;

  // R3: a barrier that watches loads cannot complete while loads remain
  a_r3_loads_block_done: assert property (@(posedge clk) disable iff (!rstN)
    (strb.needLoadsIdle && pendLoads != ZERO_CNT) |-> !condMet);

  // R5: store-only wait ignores the load count
  a_r5_io_skips_loads: assert property (@(posedge clk) disable iff (!rstN)
    (strb.needStoresIdle && !strb.needLoadsIdle && pendStores == ZERO_CNT) |-> condMet);

endmodule

// File: rtl/barrier_ctrl.sv
module barrier_ctrl
  import barrier_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         barReq,
  input  logic [1:0]   barType,
  input  logic         condMet,
  output gateStrobes_t strb,
  output logic         barReady,
  output logic         flushReq,
  output logic         barDone
);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_FLUSH,
    ST_SETTLE
  } gateState_e;

  gateState_e state, nextState;
  barKind_e   kind;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      kind  <= BAR_FULL;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && barReq) kind <= barKind_e'(barType);
    end
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    barReady  = 1'b0;
    flushReq  = 1'b0;
    barDone   = 1'b0;
    case (state)
      ST_IDLE: begin
        barReady = 1'b1;
        if (barReq)
          nextState = (barKind_e'(barType) == BAR_ISYNC) ? ST_FLUSH : ST_DRAIN;
      end
      ST_DRAIN: begin
        strb.holdStores     = 1'b1;
        strb.holdLoads      = (kind == BAR_FULL);
        strb.needStoresIdle = 1'b1;
        strb.needLoadsIdle  = (kind != BAR_IO);
        if (condMet) begin
          barDone   = 1'b1;
          nextState = ST_IDLE;
        end
      end
      ST_FLUSH: begin
        strb.holdStores = 1'b1;
        strb.holdLoads  = 1'b1;
        flushReq        = 1'b1;
        nextState       = ST_SETTLE;
      end
      default: begin
        strb.holdStores = 1'b1;
        strb.holdLoads  = 1'b1;
        barDone         = 1'b1;
        nextState       = ST_IDLE;
      end
    endcase
  end

  a_r2_accept_closes: assert property (@(posedge clk) disable iff (!rstN)
    (barReq && barReady) |=> !barReady);

  a_r6_flush_then_done: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> (barDone && !flushReq));

  a_r7_done_reopens: assert property (@(posedge clk) disable iff (!rstN)
    barDone |=> (barReady && !barDone));

endmodule

// File: rtl/barrier_gate.sv
module barrier_gate
  import barrier_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] pendLoads,
  input  logic [CNT_W-1:0] pendStores,
  input  logic             barReq,
  input  logic [1:0]       barType,
  output logic             barReady,
  output logic             loadStall,
  output logic             storeStall,
  output logic             flushReq,
  output logic             barDone
);

  gateStrobes_t strb;
  logic         condMet;

  barrier_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .barReq   (barReq),
    .barType  (barType),
    .condMet  (condMet),
    .strb     (strb),
    .barReady (barReady),
    .flushReq (flushReq),
    .barDone  (barDone)
  );

  barrier_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .pendLoads  (pendLoads),
    .pendStores (pendStores),
    .strb       (strb),
    .condMet    (condMet),
    .loadStall  (loadStall),
    .storeStall (storeStall)
  );

  // R4: a load stall never appears without a store stall
  a_r4_loads_imply_stores: assert property (@(posedge clk) disable iff (!rstN)
    loadStall |-> storeStall);

  // R1: nothing is stalled while the gate is open
  a_r1_ready_no_stall: assert property (@(posedge clk) disable iff (!rstN)
    barReady |-> (!loadStall && !storeStall && !flushReq));

endmodule

// File: tb/barrier_gate_test.sv
`timescale 1ns/100ps
module barrier_gate_test;

  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [CNT_W-1:0] pendLoads = '0;
  logic [CNT_W-1:0] pendStores = '0;
  logic             barReq = 1'b0;
  logic [1:0]       barType = 2'b00;
  logic             barReady, loadStall, storeStall, flushReq, barDone;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  barrier_gate #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .pendLoads(pendLoads), .pendStores(pendStores),
    .barReq(barReq), .barType(barType), .barReady(barReady),
    .loadStall(loadStall), .storeStall(storeStall), .flushReq(flushReq),
    .barDone(barDone)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one barrier: loads drain after dL pending cycles, stores after dS
  task automatic runBarrier(input int kind, input int dL, input int dS);
    int expDone;
    bit holdsLoads;
    if (kind == 3) expDone = 2;
    else if (kind == 2) expDone = dS + 1;
    else expDone = ((dL > dS) ? dL : dS) + 1;
    holdsLoads = (kind == 0 || kind == 3);
    @(negedge clk);
    #1;
    check("R2 ready before accept", int'(barReady), 1);
    barReq  = 1'b1;
    barType = kind[1:0];
    for (int p = 1; p <= expDone; p++) begin
      @(negedge clk);
      // conflicting request while busy, must be ignored (R2)
      barReq     = (p < expDone);
      barType    = 2'b11;
      pendLoads  = (p <= dL) ? CNT_W'(dL - p + 1) : '0;
      pendStores = (p <= dS) ? CNT_W'(dS - p + 1) : '0;
      #1;
      check("R2 ready low while pending", int'(barReady), 0);
      check("R3 R4 R6 load stall", int'(loadStall), int'(holdsLoads));
      check("R3 R4 R5 store stall", int'(storeStall), 1);
      check("R6 flush pulse", int'(flushReq), int'(kind == 3 && p == 1));
      if (kind == 0) check("R3 done timing", int'(barDone), int'(p == expDone));
      else if (kind == 1) check("R4 done timing", int'(barDone), int'(p == expDone));
      else if (kind == 2) check("R5 done timing", int'(barDone), int'(p == expDone));
      else check("R6 done timing", int'(barDone), int'(p == expDone));
      if (p == 1 && expDone == 1) check("R8 immediate done", int'(barDone), 1);
    end
    @(negedge clk);
    barReq = 1'b0;
    pendLoads = '0;
    pendStores = '0;
    #1;
    check("R7 ready after done", int'(barReady), 1);
    check("R7 done single pulse", int'(barDone), 0);
    check("R7 stalls released", int'(loadStall | storeStall | flushReq), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 values during and right after reset
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check("R1 ready", int'(barReady), 1);
    check("R1 stalls", int'(loadStall | storeStall), 0);
    check("R1 flush/done", int'(flushReq | barDone), 0);

    for (int k = 0; k < 4; k++)
      for (int dl = 0; dl < 4; dl++)
        for (int ds = 0; ds < 4; ds++)
          runBarrier(k, dl, ds);

    // R5: I/O barrier completes with loads never draining
    @(negedge clk);
    barReq = 1'b1; barType = 2'b10; pendLoads = 4'd7; pendStores = '0;
    @(negedge clk);
    barReq = 1'b0;
    #1;
    check("R5 done despite loads", int'(barDone), 1);
    check("R5 no load stall", int'(loadStall), 0);
    @(negedge clk);
    pendLoads = '0;

    // R2: request held across completion is taken the next cycle
    @(negedge clk);
    barReq = 1'b1; barType = 2'b01; pendStores = 4'd1;
    @(negedge clk);
    barType = 2'b11; pendStores = '0;
    #1;
    check("R2 done while request held", int'(barDone), 1);
    check("R2 refused in done cycle", int'(barReady), 0);
    @(negedge clk);
    #1;
    check("R2 ready reopened", int'(barReady), 1);
    @(negedge clk);
    barReq = 1'b0;
    #1;
    check("R2 held request now flushing", int'(flushReq), 1);
    @(negedge clk);
    #1;
    check("R6 second cycle done", int'(barDone), 1);
    @(negedge clk);
    #1;
    check("R7 idle again", int'(barReady), 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule